// File: doc/BRIEF.md
# 8-bit Load Execution Unit

This block fetches and runs the byte-load subset of a classic 8-bit processor instruction set. Its timing matches that processor cycle for cycle. It holds seven byte registers (A, B, C, D, E, H, L), two 16-bit index registers and a program counter. It talks to a byte-wide synchronous memory through one address bus, a read strobe, a write strobe and a pair of data buses.

Each instruction runs as a short sequence of machine cycles, and each machine cycle has a fixed number of clock states:

- An opcode fetch lasts 4 states.
- An operand or data access lasts 3 states.
- The address calculation for an indexed access is an internal cycle of 5 states.

The unit supports the following forms:

- register-to-register copy
- immediate load
- load through the HL pair, in either direction
- indexed load with a signed displacement, in either direction
- HALT

Every other opcode behaves as a 4-state no-operation.

A one-cycle `instr_done` pulse marks the last clock state of every instruction. This lets surrounding logic or a testbench check instruction boundaries and total state counts.

Top module: `ldx_load_unit`

## Requirements
- R1: A synchronous active-high reset clears the program counter, all byte registers, both index registers and the halted state. The first fetch after reset is from address 0x0000.
- R2: The 3-bit register selector encodes B=000, C=001, D=010, E=011, H=100, L=101, A=111. Code 110 means the memory byte addressed by {H,L}.
- R3: Opcode 01 ddd sss, with neither field equal to 110, copies register sss into register ddd in 4 clock states.
- R4: Opcode 00 ddd 110 (ddd not 110) loads the byte that follows it into ddd. It takes 7 clock states (4+3), and the program counter moves past the immediate byte.
- R5: Opcode 01 ddd 110 reads memory at {H,L} into ddd in 7 clock states (4+3). The read strobe and address are held for the whole read cycle, and data is taken in the last state of that cycle.
- R6: Opcode 01110 sss writes register sss to memory at {H,L} in 7 clock states (4+3). The write strobe is high for exactly one clock, in the final state, with address and data stable.
- R7: After prefix 0xDD (index X) or 0xFD (index Y), opcode 01 ddd 110 reads memory at index + sign-extended displacement (modulo 2^16) into ddd. The displacement byte follows the opcode. The instruction takes 19 clock states (4,4,3,5,3).
- R8: After either prefix, opcode 01110 sss writes sss to index + sign-extended displacement (modulo 2^16) in 19 clock states (4,4,3,5,3).
- R9: Opcode 0x76 is HALT and takes 4 clock states. After it, `halted` is high and the unit makes no further fetch, read, write or done pulse until reset.
- R10: Any other unprefixed opcode takes 4 clock states and changes no register.
- R11: A prefix followed by an opcode that is not an indexed load adds 4 clock states. The opcode then executes as if it had no prefix.
- R12: `instr_done` is a single-cycle pulse in the last clock state of each instruction. It is never asserted for a prefix byte alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe, held for a whole read machine cycle |
| mem_wr | output | 1 | Write strobe, one clock in the final state of a write cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data from memory |
| instr_done | output | 1 | Pulse in the last clock state of each instruction |
| halted | output | 1 | High after HALT until reset |

## Verification
The assertions assume that `mem_rdata` comes from a registered memory. That memory captures the addressed byte on the edge that closes the first state of a read cycle and holds it until the next read. They also assume that reset is applied long enough for the synchronous clear to take effect.

The bench memory model follows this rule exactly and preloads every address the program reads. The program contains only supported forms and no-operation opcodes without operands, so every instruction's byte count is known in advance. All index and HL addresses are chosen so that data accesses do not overlap instruction bytes still to be fetched.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int SEL_W    = 3;
    localparam int SLOTS    = 1 << SEL_W;
    localparam int MEM_CODE = 6;
    localparam int TS_W     = 3;

    localparam logic [SEL_W-1:0]  SEL_MEM = SEL_W'(MEM_CODE);
    localparam logic [SEL_W-1:0]  SEL_H   = 3'b100;
    localparam logic [SEL_W-1:0]  SEL_L   = 3'b101;
    localparam logic [DATA_W-1:0] OPC_PFX_X = 8'hDD;
    localparam logic [DATA_W-1:0] OPC_PFX_Y = 8'hFD;
    localparam logic [DATA_W-1:0] OPC_HALT  = 8'h76;

    // machine cycle kinds
    typedef enum logic [2:0] {
        MC_FETCH,   // opcode or prefix fetch
        MC_OPRD,    // immediate or displacement read at PC
        MC_CALC,    // indexed address calculation
        MC_MRD,     // data read
        MC_MWR      // data write
    } mcyc_e;

    typedef enum logic [1:0] {
        IDX_NONE,
        IDX_X,
        IDX_Y
    } idx_e;

    typedef enum logic [3:0] {
        K_NOP,
        K_PFX_X,
        K_PFX_Y,
        K_COPY,
        K_IMM,
        K_RD_HL,
        K_WR_HL,
        K_RD_IDX,
        K_WR_IDX,
        K_HALT
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [SEL_W-1:0] dst;
        logic [SEL_W-1:0] src;
    } dec_t;

    // clock states per machine cycle
    function automatic logic [TS_W-1:0] mc_len(mcyc_e m);
        case (m)
            MC_FETCH: return TS_W'(4);
            MC_CALC:  return TS_W'(5);
            default:  return TS_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/ldx_tstate.sv
module ldx_tstate
    import ldx_pkg::*;
#(
    parameter int CNT_W = TS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ldx_decode.sv
module ldx_decode
    import ldx_pkg::*;
(
    input  logic [DATA_W-1:0] opcode,
    input  logic              idx_on,
    output dec_t              dec
);
    logic [1:0]       grp;
    logic [SEL_W-1:0] fd;
    logic [SEL_W-1:0] fs;

    assign grp = opcode[7:6];
    assign fd  = opcode[5:3];
    assign fs  = opcode[2:0];

    always_comb begin
        dec.kind = K_NOP;
        dec.dst  = fd;
        dec.src  = fs;
        if (opcode == OPC_PFX_X) begin
            dec.kind = K_PFX_X;
        end else if (opcode == OPC_PFX_Y) begin
            dec.kind = K_PFX_Y;
        end else if (opcode == OPC_HALT) begin
            dec.kind = K_HALT;
        end else if (grp == 2'b01) begin
            if (fs == SEL_MEM) begin
                dec.kind = idx_on ? K_RD_IDX : K_RD_HL;
            end else if (fd == SEL_MEM) begin
                dec.kind = idx_on ? K_WR_IDX : K_WR_HL;
            end else begin
                dec.kind = K_COPY;
            end
        end else if (grp == 2'b00 && fs == SEL_MEM && fd != SEL_MEM) begin
            dec.kind = K_IMM;
        end
    end
endmodule

// File: rtl/ldx_regfile.sv
module ldx_regfile
    import ldx_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] rsel,
    output logic [W-1:0]  rdata,
    output logic [2*W-1:0] hl
);
    localparam int N = 1 << SW;

    logic [W-1:0] slot_w [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        if (g == MEM_CODE) begin : g_hole
            assign slot_w[g] = '0;
        end else begin : g_reg
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && wsel == SW'(g)) begin
                    q <= wdata;
                end
            end
            assign slot_w[g] = q;
        end
    end

    assign rdata = slot_w[rsel];
    assign hl    = {slot_w[SEL_H], slot_w[SEL_L]};
endmodule

// File: rtl/ldx_agen.sv
module ldx_agen
    import ldx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  idx_e          sel,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] ea
);
    logic [AW-1:0] ix_q;
    logic [AW-1:0] iy_q;
    logic [AW-1:0] base;

    // index registers: cleared by reset, no load path in this subset
    always_ff @(posedge clk) begin
        if (rst) begin
            ix_q <= '0;
            iy_q <= '0;
        end else begin
            ix_q <= ix_q;
            iy_q <= iy_q;
        end
    end

    assign base = (sel == IDX_Y) ? iy_q : ix_q;
    assign ea   = base + AW'($signed(disp));
endmodule

// File: rtl/ldx_load_unit.sv
module ldx_load_unit
    import ldx_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              instr_done,
    output logic              halted
);
    mcyc_e             mc_q, mc_n;
    idx_e              idx_q, idx_n;
    dec_t              op_q, op_n;
    dec_t              dec;
    logic [AW-1:0]     pc_q, pc_n;
    logic [AW-1:0]     ea_q, ea_n;
    logic [DATA_W-1:0] disp_q, disp_n;
    logic              halted_q, halted_n;
    logic              t_last;
    logic              done;

    logic              rf_we;
    logic [SEL_W-1:0]  rf_wsel;
    logic [DATA_W-1:0] rf_wdata;
    logic [SEL_W-1:0]  rf_rsel;
    logic [DATA_W-1:0] rf_rdata;
    logic [2*DATA_W-1:0] rf_hl;
    logic [AW-1:0]     ea_idx;

    ldx_tstate #(.CNT_W(TS_W)) u_tstate (
        .clk  (clk),
        .rst  (rst),
        .run  (!halted_q),
        .len  (mc_len(mc_q)),
        .last (t_last)
    );

    ldx_decode u_decode (
        .opcode (mem_rdata),
        .idx_on (idx_q != IDX_NONE),
        .dec    (dec)
    );

    assign rf_rsel = (mc_q == MC_FETCH) ? dec.src : op_q.src;

    ldx_regfile #(.W(DATA_W), .SW(SEL_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .wsel  (rf_wsel),
        .wdata (rf_wdata),
        .rsel  (rf_rsel),
        .rdata (rf_rdata),
        .hl    (rf_hl)
    );

    ldx_agen #(.AW(AW), .DW(DATA_W)) u_agen (
        .clk  (clk),
        .rst  (rst),
        .sel  (idx_q),
        .disp (disp_q),
        .ea   (ea_idx)
    );

    always_comb begin
        mc_n     = mc_q;
        idx_n    = idx_q;
        op_n     = op_q;
        pc_n     = pc_q;
        ea_n     = ea_q;
        disp_n   = disp_q;
        halted_n = halted_q;
        done     = 1'b0;
        rf_we    = 1'b0;
        rf_wsel  = op_q.dst;
        rf_wdata = mem_rdata;
        if (!halted_q && t_last) begin
            case (mc_q)
                MC_FETCH: begin
                    pc_n = pc_q + AW'(1);
                    case (dec.kind)
                        K_PFX_X: idx_n = IDX_X;
                        K_PFX_Y: idx_n = IDX_Y;
                        K_COPY: begin
                            rf_we    = 1'b1;
                            rf_wsel  = dec.dst;
                            rf_wdata = rf_rdata;
                            done     = 1'b1;
                            idx_n    = IDX_NONE;
                        end
                        K_IMM, K_RD_IDX, K_WR_IDX: begin
                            op_n = dec;
                            mc_n = MC_OPRD;
                        end
                        K_RD_HL: begin
                            op_n = dec;
                            ea_n = AW'(rf_hl);
                            mc_n = MC_MRD;
                        end
                        K_WR_HL: begin
                            op_n = dec;
                            ea_n = AW'(rf_hl);
                            mc_n = MC_MWR;
                        end
                        K_HALT: begin
                            halted_n = 1'b1;
                            done     = 1'b1;
                            idx_n    = IDX_NONE;
                        end
                        default: begin
                            done  = 1'b1;
                            idx_n = IDX_NONE;
                        end
                    endcase
                end
                MC_OPRD: begin
                    pc_n = pc_q + AW'(1);
                    if (op_q.kind == K_IMM) begin
                        rf_we = 1'b1;
                        done  = 1'b1;
                        idx_n = IDX_NONE;
                        mc_n  = MC_FETCH;
                    end else begin
                        disp_n = mem_rdata;
                        mc_n   = MC_CALC;
                    end
                end
                MC_CALC: begin
                    ea_n = ea_idx;
                    mc_n = (op_q.kind == K_RD_IDX) ? MC_MRD : MC_MWR;
                end
                MC_MRD: begin
                    rf_we = 1'b1;
                    done  = 1'b1;
                    idx_n = IDX_NONE;
                    mc_n  = MC_FETCH;
                end
                MC_MWR: begin
                    done  = 1'b1;
                    idx_n = IDX_NONE;
                    mc_n  = MC_FETCH;
                end
                default: mc_n = MC_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q     <= MC_FETCH;
            idx_q    <= IDX_NONE;
            op_q     <= '0;
            pc_q     <= '0;
            ea_q     <= '0;
            disp_q   <= '0;
            halted_q <= 1'b0;
        end else begin
            mc_q     <= mc_n;
            idx_q    <= idx_n;
            op_q     <= op_n;
            pc_q     <= pc_n;
            ea_q     <= ea_n;
            disp_q   <= disp_n;
            halted_q <= halted_n;
        end
    end

    assign mem_addr   = (mc_q == MC_MRD || mc_q == MC_MWR) ? ea_q : pc_q;
    assign mem_rd     = !halted_q && (mc_q == MC_FETCH || mc_q == MC_OPRD || mc_q == MC_MRD);
    assign mem_wr     = !halted_q && (mc_q == MC_MWR) && t_last;
    assign mem_wdata  = rf_rdata;
    assign instr_done = done;
    assign halted     = halted_q;
endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk
    import ldx_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              instr_done,
    input logic              halted
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && !halted && !mem_wr));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    // R6
    wr_final_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> instr_done);

    // R6
    wr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($stable(mem_addr) && $stable(mem_wdata)));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr && !instr_done));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> !instr_done);
endmodule

bind ldx_load_unit ldx_unit_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .instr_done (instr_done),
    .halted     (halted)
);

// File: tb/ldx_load_unit_bench.sv
`timescale 1ns/1ps
module ldx_load_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        instr_done;
    logic        halted;

    always #2.5 clk = ~clk;

    ldx_load_unit u_ldx_load_unit (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .instr_done (instr_done),
        .halted     (halted)
    );

    // registered byte memory
    logic [7:0] mem [logic [15:0]];
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
        if (mem_wr) mem[mem_addr] = mem_wdata;
    end

    typedef struct { int tlen; string tag; } tex_t;
    typedef struct { int a; int d; string tag; } wex_t;
    tex_t tq[$];
    wex_t wq[$];
    tex_t tcur;
    wex_t wcur;
    int   checks = 0;
    int   errors = 0;
    int   tcnt   = 0;
    bit   mon_en = 1'b0;
    logic [15:0] ld_ptr = 16'h0000;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        mem[ld_ptr] = b;
        ld_ptr = ld_ptr + 16'd1;
    endtask

    task automatic exp_t(input int t, input string tag);
        tq.push_back('{t, tag});
    endtask

    task automatic exp_w(input int a, input int d, input string tag);
        wq.push_back('{a, d, tag});
    endtask

    // monitor: pops expectations as the design produces results
    always @(negedge clk) begin
        if (mon_en) begin
            tcnt++;
            if (instr_done) begin
                if (tq.size() == 0) begin
                    check(1'b0, "R12", "unexpected done pulse", tcnt, 0);
                end else begin
                    tcur = tq.pop_front();
                    check(tcnt == tcur.tlen, tcur.tag, "clock states", tcnt, tcur.tlen);
                end
                tcnt = 0;
            end
            if (mem_wr) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R6", "unexpected write", int'(mem_addr), 0);
                end else begin
                    wcur = wq.pop_front();
                    check(int'(mem_addr) == wcur.a, wcur.tag, "write address", int'(mem_addr), wcur.a);
                    check(int'(mem_wdata) == wcur.d, wcur.tag, "write data", int'(mem_wdata), wcur.d);
                end
            end
        end
    end

    initial begin
        // data preloads
        mem[16'h8011] = 8'hA7;
        mem[16'hFFFE] = 8'hC3;
        // program; selector codes per R2 (B=000 C=001 D=010 E=011 H=100 L=101 A=111)
        put(8'h77);             exp_t(7, "R1");  exp_w(16'h0000, 8'h00, "R1");  // A and HL zero
        put(8'h06); put(8'h5A); exp_t(7, "R4");  // B=5A
        put(8'h0E); put(8'h3C); exp_t(7, "R4");  // C=3C
        put(8'h50);             exp_t(4, "R3");  // D=B
        put(8'h59);             exp_t(4, "R3");  // E=C
        put(8'h26); put(8'h80); exp_t(7, "R4");  // H=80
        put(8'h2E); put(8'h10); exp_t(7, "R4");  // L=10
        put(8'h72);             exp_t(7, "R6");  exp_w(16'h8010, 8'h5A, "R3");
        put(8'h73);             exp_t(7, "R6");  exp_w(16'h8010, 8'h3C, "R3");
        put(8'h2E); put(8'h11); exp_t(7, "R4");  // L=11
        put(8'h7E);             exp_t(7, "R5");  // A=(HL)=A7
        put(8'h77);             exp_t(7, "R6");  exp_w(16'h8011, 8'hA7, "R5");
        put(8'hDD); put(8'h4E); put(8'hFE); exp_t(19, "R7");  // C=(IX-2)
        put(8'h71);             exp_t(7, "R6");  exp_w(16'h8011, 8'hC3, "R7");
        put(8'hFD); put(8'h5E); put(8'h01); exp_t(19, "R7");  // E=(IY+1)=06
        put(8'h73);             exp_t(7, "R6");  exp_w(16'h8011, 8'h06, "R7");
        put(8'hFD); put(8'h71); put(8'h7F); exp_t(19, "R8");  exp_w(16'h007F, 8'hC3, "R8");
        put(8'hDD); put(8'h77); put(8'h80); exp_t(19, "R8");  exp_w(16'hFF80, 8'hA7, "R8");
        put(8'h3C);             exp_t(4, "R10");
        put(8'h04);             exp_t(4, "R10");
        put(8'h70);             exp_t(7, "R6");  exp_w(16'h8011, 8'h5A, "R10"); // B untouched
        put(8'hDD); put(8'h41); exp_t(8, "R11"); // B=C via plain copy
        put(8'h70);             exp_t(7, "R6");  exp_w(16'h8011, 8'hC3, "R11");
        put(8'h63);             exp_t(4, "R3");  // H=E=06
        put(8'h6F);             exp_t(4, "R3");  // L=A=A7
        put(8'h74);             exp_t(7, "R2");  exp_w(16'h06A7, 8'h06, "R2");
        put(8'h75);             exp_t(7, "R2");  exp_w(16'h06A7, 8'hA7, "R2");
        put(8'h7F);             exp_t(4, "R3");
        put(8'h77);             exp_t(7, "R6");  exp_w(16'h06A7, 8'hA7, "R3");
        put(8'hFD); put(8'h46); put(8'h10); exp_t(19, "R7");  // B=(0010)=77
        put(8'h70);             exp_t(7, "R6");  exp_w(16'h06A7, 8'h77, "R7");
        put(8'h76);             exp_t(4, "R9");

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        check(mem_addr == 16'h0000, "R1", "first fetch address", int'(mem_addr), 0);
        check(mem_rd == 1'b1, "R1", "first fetch strobe", int'(mem_rd), 1);
        check(halted == 1'b0, "R1", "halted after reset", int'(halted), 0);

        for (int i = 0; i < 4000 && !halted; i++) @(negedge clk);
        if (!halted) begin
            check(1'b0, "R9", "watchdog expired before halt", 0, 1);
        end else begin
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                check(halted && !mem_rd && !mem_wr && !instr_done, "R9", "activity while halted",
                      int'({halted, mem_rd, mem_wr, instr_done}), 8);
            end
        end
        check(tq.size() == 0, "R12", "instructions left unfinished", tq.size(), 0);
        check(wq.size() == 0, "R6", "writes left unseen", wq.size(), 0);

        mon_en = 1'b0;
        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(halted == 1'b0, "R9", "halt cleared by reset", int'(halted), 0);
        check(mem_addr == 16'h0000, "R1", "address after second reset", int'(mem_addr), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule